// File: doc/BRIEF.md
# Idle-Qualified Clock Gate Hint Controller

This block resolves the enables for a group of transactional clocks. Software owns one hint bit per clock. A hint of 1 forces the clock on at the next edge. A hint of 0 is only a request to turn the clock off. Hardware carries out that request once the unit served by the clock reports idle. While the unit is busy, the clock is kept running.

A low-power request overrides every hint and gates all clocks in the group. A second output vector mirrors the resolved enable of each clock. Software reads it to learn whether a requested shutdown has actually happened. The enables drive clock-gating cells that sit outside this block.

Top module: `clk_hint_ctrl`

## Requirements
- R1: After reset, every bit of `clk_en_o` and every bit of `status_o` is 1.
- R2: With `lowpwr_i` low and hint bit i at 1, enable bit i is 1 after the next rising edge, whatever idle bit i is.
- R3: With `lowpwr_i` low, hint bit i at 0 and idle bit i at 1, enable bit i is 0 after the next rising edge.
- R4: With `lowpwr_i` low, hint bit i at 0 and idle bit i at 0, an enable bit that is 1 stays 1.
- R5: With `lowpwr_i` low and hint bit i at 0, an enable bit that is 0 stays 0 when idle bit i falls. It returns to 1 only when hint bit i becomes 1.
- R6: While `lowpwr_i` is 1, every enable bit is 0 after the next rising edge, whatever the hints and idle bits are.
- R7: After `lowpwr_i` falls, clocks whose hint is 1 turn on at the next edge. Clocks whose hint is 0 stay off, whether or not their unit is idle.
- R8: `status_o` equals `clk_en_o` in every cycle and changes in the same cycle.
- R9: Bit i of `hint_i`, `idle_i`, `clk_en_o` and `status_o` all refer to clock i. Each clock is resolved independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hint_i | input | NUM_CLK | Software hint per clock (1 = keep on, 0 = may turn off) |
| idle_i | input | NUM_CLK | Idle indication from the unit behind each clock |
| lowpwr_i | input | 1 | Low-power request; gates every clock while high |
| clk_en_o | output | NUM_CLK | Resolved enable for each clock-gating cell |
| status_o | output | NUM_CLK | Read-back copy of the resolved enables |

## Verification
The bench aims at the asymmetry between the two hint values.

- A hint of 0 with a busy unit must keep the clock running. A design that gated on the hint alone would stop a busy unit.
- A clock that is already off must not come back when its unit turns busy again. A design that re-derived the enable from the idle input alone would wake the clock without a hint.
- Low-power entry and exit are checked with mixed hints. This catches a design that restored the pre-sleep enables, and one that let low power lose to a 1 hint.
- The status copy is compared with the enable in every test. This catches a status path that lags by one cycle.
- A behavioural gated clock confirms that edges stop while gated.

// File: rtl/clk_hint_pkg.sv
package clk_hint_pkg;

   // Action resolved for one clock in one cycle
   typedef enum logic [1:0] {
      GATE_HOLD = 2'd0,
      GATE_ON   = 2'd1,
      GATE_OFF  = 2'd2
   } gate_act_e;

   localparam int unsigned MAX_CLOCKS = 32;

   function automatic logic gate_apply(input gate_act_e act, input logic cur);
      case (act)
         GATE_ON:  return 1'b1;
         GATE_OFF: return 1'b0;
         default:  return cur;
      endcase
   endfunction

endpackage

// File: rtl/hint_gate_decide.sv
module hint_gate_decide
   import clk_hint_pkg::*;
(
   input  logic      hint_i,
   input  logic      idle_i,
   input  logic      lowpwr_i,
   output gate_act_e act_o
);

   // Priority: low power, then an on hint, then an idle-qualified off request
   always_comb begin
      if (lowpwr_i)     act_o = GATE_OFF;
      else if (hint_i)  act_o = GATE_ON;
      else if (idle_i)  act_o = GATE_OFF;
      else              act_o = GATE_HOLD;
   end

endmodule

// File: rtl/hint_gate_cell.sv
module hint_gate_cell
   import clk_hint_pkg::*;
#(
   parameter logic RESET_EN = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hint_i,
   input  logic idle_i,
   input  logic lowpwr_i,
   output logic en_d_o,
   output logic en_o
);

   gate_act_e act;
   logic      en_q;

   hint_gate_decide u_decide (
      .hint_i   (hint_i),
      .idle_i   (idle_i),
      .lowpwr_i (lowpwr_i),
      .act_o    (act)
   );

   assign en_d_o = gate_apply(act, en_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= RESET_EN;
      else         en_q <= en_d_o;
   end

   assign en_o = en_q;

   assert_lowpwr_gates_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lowpwr_i |=> !en_q);
   assert_hint_on_immediate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lowpwr_i && hint_i) |=> en_q);
   assert_idle_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lowpwr_i && !hint_i && idle_i) |=> !en_q);
   assert_busy_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lowpwr_i && !hint_i && !idle_i && en_q) |=> en_q);
   assert_off_stays_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lowpwr_i && !hint_i && !en_q) |=> !en_q);

endmodule

// File: rtl/hint_status_mirror.sv
module hint_status_mirror #(
   parameter int unsigned         WIDTH     = 5,
   parameter logic [WIDTH-1:0]    RESET_VAL = '1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] next_i,
   output logic [WIDTH-1:0] status_o
);

   // Loads the same next-state the enable registers load, so it never lags
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_o <= RESET_VAL;
      else         status_o <= next_i;
   end

endmodule

// File: rtl/clk_hint_ctrl.sv
module clk_hint_ctrl
   import clk_hint_pkg::*;
#(
   parameter int unsigned NUM_CLK = 5
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_CLK-1:0] hint_i,
   input  logic [NUM_CLK-1:0] idle_i,
   input  logic               lowpwr_i,
   output logic [NUM_CLK-1:0] clk_en_o,
   output logic [NUM_CLK-1:0] status_o
);

   localparam logic [NUM_CLK-1:0] RESET_VEC = {NUM_CLK{1'b1}};

   if (NUM_CLK < 1 || NUM_CLK > MAX_CLOCKS) begin : g_bad_width
      $error("clk_hint_ctrl: NUM_CLK out of range");
   end

   logic [NUM_CLK-1:0] en_next;

   for (genvar i = 0; i < NUM_CLK; i++) begin : g_clk
      hint_gate_cell #(
         .RESET_EN (RESET_VEC[i])
      ) u_cell (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .hint_i   (hint_i[i]),
         .idle_i   (idle_i[i]),
         .lowpwr_i (lowpwr_i),
         .en_d_o   (en_next[i]),
         .en_o     (clk_en_o[i])
      );
   end

   hint_status_mirror #(
      .WIDTH     (NUM_CLK),
      .RESET_VAL (RESET_VEC)
   ) u_status (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .next_i   (en_next),
      .status_o (status_o)
   );

   assert_status_tracks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o == clk_en_o);
   assert_lp_exit_hint0_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lowpwr_i && $past(lowpwr_i) && hint_i == '0) |=> clk_en_o == '0);

endmodule

// File: tb/clk_hint_ctrl_bench.sv
`timescale 1ns/1ps
module clk_hint_ctrl_bench;

   localparam int N = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] hint = '1;
   logic [N-1:0] idle = '0;
   logic         lowpwr = 1'b0;
   logic [N-1:0] en;
   logic [N-1:0] status;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   clk_hint_ctrl #(.NUM_CLK(N)) u_clk_hint_ctrl (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .hint_i   (hint),
      .idle_i   (idle),
      .lowpwr_i (lowpwr),
      .clk_en_o (en),
      .status_o (status)
   );

   // Behavioural gate on clock 0: enable latched while clk is low
   logic en0_lat;
   logic gclk0;
   int   gcount = 0;
   always_latch if (!clk) en0_lat = en[0];
   assign gclk0 = clk & en0_lat;
   always @(posedge gclk0) gcount = gcount + 1;

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_both(input string req, input logic [N-1:0] exp);
      check(req, en, exp);
      check({req, " status R8"}, status, exp);
   endtask

   task automatic t_reset();
      check_both("R1 reset", 5'b11111);
   endtask

   task automatic t_idle_off();
      hint = 5'b00000; idle = 5'b10101;
      tick();
      check_both("R3 R9 idle units off", 5'b01010);
      idle = 5'b00000;
      tick();
      check_both("R4 R5 busy keeps state", 5'b01010);
      tick();
      check_both("R5 off stays off", 5'b01010);
      idle = 5'b11111;
      tick();
      check_both("R3 all idle off", 5'b00000);
   endtask

   task automatic t_hint_on();
      hint = 5'b00011; idle = 5'b11111;
      tick();
      check_both("R2 on despite idle", 5'b00011);
      hint = 5'b11111; idle = 5'b00000;
      tick();
      check_both("R2 R5 hint restores", 5'b11111);
   endtask

   task automatic t_busy_hold();
      hint = 5'b00000; idle = 5'b00000;
      for (int k = 0; k < 3; k++) begin
         tick();
         check_both("R4 busy hold", 5'b11111);
      end
      idle = 5'b00100;
      tick();
      check_both("R3 R9 single idle", 5'b11011);
      hint = 5'b11111; idle = 5'b00000;
      tick();
   endtask

   task automatic t_lowpower();
      int c0;
      hint = 5'b11111; idle = 5'b00000; lowpwr = 1'b1;
      tick();
      check_both("R6 low power gates", 5'b00000);
      c0 = gcount;
      tick(); tick(); tick();
      total++;
      if (gcount != c0) begin
         bad++;
         $display("FAIL R6 gated clock ran: actual=%0d expected=%0d", gcount, c0);
      end
      check_both("R6 still gated", 5'b00000);
      hint = 5'b10101; idle = 5'b01000; lowpwr = 1'b0;
      tick();
      check_both("R7 exit follows hint", 5'b10101);
      idle = 5'b00000;
      tick();
      check_both("R7 R5 hint0 stays off", 5'b10101);
      hint = 5'b11111;
      tick();
      check_both("R2 all on after exit", 5'b11111);
      c0 = gcount;
      tick();
      total++;
      if (gcount == c0) begin
         bad++;
         $display("FAIL R2 gated clock stopped: actual=%0d expected>%0d", gcount, c0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle_off();
      t_hint_on();
      t_busy_hold();
      t_lowpower();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule